// File: doc/BRIEF.md
# Time Snapshot Event Controller

This block watches two asynchronous auxiliary inputs, a one-cycle pulse-per-second tick and a 64-bit system time bus. On a synchronized rising edge of an auxiliary input it stores the current time into that channel's 64-bit snapshot. It also raises a sticky flag when the time reaches a programmed target, and it flags each second tick. All flags are held in one event register that software acknowledges by writing ones. A control register carries a per-source interrupt mask and a soft-clear bit. The block drives one level-sensitive interrupt line, which may be shared with other sources.

The time counter is not part of this block; it arrives on `sys_time`. Software reaches the registers through a single-cycle write port and a combinational read port. The map uses a 3-bit word address:

| Address | Register |
|---|---|
| 0 | control |
| 1 | event |
| 2 | target low word |
| 3 | target high word |
| 4 | slave snapshot low |
| 5 | slave snapshot high |
| 6 | master snapshot low |
| 7 | master snapshot high |

A typical service routine reads the event register and reads each flagged snapshot. It then acknowledges all handled bits with one write.

Top module: `tsnap_event_ctrl`

## Requirements
- R1: While `rst` is high, and right after it, control, event, target and both snapshots read 0 and `irq` is 0.
- R2: A rising edge on `aux_slave_in` is seen on the third rising clock edge after the input changes, which allows two synchronizer flops. On that edge `sys_time` is stored into the slave snapshot (low word at address 4, high word at address 5) and event bit 2 sets. `aux_master_in` behaves the same way, using addresses 6 and 7 and event bit 3.
- R3: An auxiliary input that stays high, or that falls, causes no capture.
- R4: A new rising edge overwrites its channel's snapshot even while that channel's event bit is still pending. The other channel's snapshot is left unchanged.
- R5: Event bit 1 sets on the clock edge at which unsigned `sys_time` is greater than or equal to the 64-bit target (low word at address 2, high word at address 3). It stays set after the time falls back below the target.
- R6: Writing to address 1 clears each event bit written as 1 and leaves bits written as 0 unchanged. If a source sets a bit in the same cycle that it is cleared, the bit stays set.
- R7: `pps_tick` high at a clock edge sets event bit 4.
- R8: `irq` is high exactly when some event bit in positions 1 to 4 is set together with the control bit in the same position. It follows combinationally and is not latched.
- R9: While control bit 0 is set, all event bits and both snapshots are cleared and held at 0. The control mask bits and the target keep their values.
- R10: Only control bits 4 to 0 and event bits 4 to 1 exist. All other bits read 0, including event bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_time | input | 64 | Running system time in ticks |
| aux_slave_in | input | 1 | Asynchronous slave auxiliary capture input |
| aux_master_in | input | 1 | Asynchronous master auxiliary capture input |
| pps_tick | input | 1 | One-cycle second tick, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (shared by read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `pps_tick` and `sys_time` are synchronous to `clk`, and that writes on the register port are single-cycle strobes. The checks on the auxiliary inputs assume each input holds its level for at least three clocks, so every edge passes through the synchronizer. The bench drives every input at the falling clock edge. It holds each auxiliary level for four or more cycles, and it keeps `sys_time` constant while a capture is in flight, so each snapshot value is exact.

// File: rtl/tsnap_pkg.sv
package tsnap_pkg;

    localparam int WORD_W = 32;
    localparam int TIME_W = 2 * WORD_W;
    localparam int EVT_W  = 5;
    localparam int NUM_CH = 2;

    localparam int CH_SLV = 0;
    localparam int CH_MST = 1;

    // bit positions shared by control (mask) and event (flag)
    localparam int BIT_SRST = 0;
    localparam int BIT_TGT  = 1;
    localparam int BIT_SLV  = 2;
    localparam int BIT_MST  = 3;
    localparam int BIT_PPS  = 4;

    localparam logic [EVT_W-1:0] EVT_IMPL  = 5'b11110;
    localparam logic [EVT_W-1:0] CTRL_IMPL = 5'b11111;

    typedef logic [TIME_W-1:0] stamp_t;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } stamp_words_t;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_EVENT  = 3'd1,
        SEL_TGT_LO = 3'd2,
        SEL_TGT_HI = 3'd3,
        SEL_SLV_LO = 3'd4,
        SEL_SLV_HI = 3'd5,
        SEL_MST_LO = 3'd6,
        SEL_MST_HI = 3'd7
    } reg_sel_e;

    function automatic logic irq_level(input logic [EVT_W-1:0] evt,
                                       input logic [EVT_W-1:0] ctrl);
        return |(evt & ctrl & EVT_IMPL);
    endfunction

    function automatic logic [WORD_W-1:0] widen(input logic [EVT_W-1:0] v);
        return {{(WORD_W-EVT_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/tsnap_aux_chan.sv
module tsnap_aux_chan
    import tsnap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   aux_in,
    input  stamp_t sys_time,
    output logic   cap,
    output stamp_t snap
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    stamp_t                 snap_q;

    assign cap  = sync_q[SYNC_STAGES-1] & ~prev_q;
    assign snap = snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            snap_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], aux_in};
            prev_q <= sync_q[SYNC_STAGES-1];
            if (clr)
                snap_q <= '0;
            else if (cap)
                snap_q <= sys_time;
        end
    end

endmodule

// File: rtl/tsnap_target_cmp.sv
module tsnap_target_cmp
    import tsnap_pkg::*;
(
    input  stamp_t now,
    input  stamp_t target,
    output logic   hit
);

    assign hit = (now >= target);

endmodule

// File: rtl/tsnap_regs.sv
module tsnap_regs
    import tsnap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [2:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [EVT_W-1:0]  set_vec,
    input  stamp_t            snap_slv,
    input  stamp_t            snap_mst,
    output logic [WORD_W-1:0] rdata,
    output logic              irq,
    output logic [EVT_W-1:0]  ctrl_q,
    output logic [EVT_W-1:0]  evt_q,
    output stamp_t            tgt_q
);

    reg_sel_e         sel;
    logic [EVT_W-1:0] ack;
    stamp_words_t     tgt_w, slv_w, mst_w;
    logic             unused_wbits;

    assign sel          = reg_sel_e'(addr);
    assign ack          = (wr && sel == SEL_EVENT) ? wdata[EVT_W-1:0] : '0;
    assign tgt_w        = tgt_q;
    assign slv_w        = snap_slv;
    assign mst_w        = snap_mst;
    assign unused_wbits = ^wdata[WORD_W-1:EVT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            evt_q  <= '0;
            tgt_q  <= '0;
        end else begin
            if (wr && sel == SEL_CTRL)
                ctrl_q <= wdata[EVT_W-1:0] & CTRL_IMPL;
            if (wr && sel == SEL_TGT_LO)
                tgt_q[WORD_W-1:0] <= wdata;
            if (wr && sel == SEL_TGT_HI)
                tgt_q[TIME_W-1:WORD_W] <= wdata;
            if (ctrl_q[BIT_SRST])
                evt_q <= '0;
            else
                evt_q <= ((evt_q & ~ack) | set_vec) & EVT_IMPL;
        end
    end

    always_comb begin
        case (sel)
            SEL_CTRL:   rdata = widen(ctrl_q);
            SEL_EVENT:  rdata = widen(evt_q);
            SEL_TGT_LO: rdata = tgt_w.lo;
            SEL_TGT_HI: rdata = tgt_w.hi;
            SEL_SLV_LO: rdata = slv_w.lo;
            SEL_SLV_HI: rdata = slv_w.hi;
            SEL_MST_LO: rdata = mst_w.lo;
            SEL_MST_HI: rdata = mst_w.hi;
            default:    rdata = '0;
        endcase
    end

    assign irq = irq_level(evt_q, ctrl_q);

endmodule

// File: rtl/tsnap_event_ctrl.sv
module tsnap_event_ctrl
    import tsnap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] sys_time,
    input  logic              aux_slave_in,
    input  logic              aux_master_in,
    input  logic              pps_tick,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq
);

    logic [NUM_CH-1:0] aux_vec;
    logic [NUM_CH-1:0] cap_vec;
    stamp_t            snap_arr [NUM_CH];
    logic              tgt_hit;
    logic [EVT_W-1:0]  set_vec;
    logic [EVT_W-1:0]  ctrl_w;
    logic [EVT_W-1:0]  evt_w;
    stamp_t            tgt_w;

    assign aux_vec[CH_SLV] = aux_slave_in;
    assign aux_vec[CH_MST] = aux_master_in;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            tsnap_aux_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
                .clk      (clk),
                .rst      (rst),
                .clr      (ctrl_w[BIT_SRST]),
                .aux_in   (aux_vec[c]),
                .sys_time (sys_time),
                .cap      (cap_vec[c]),
                .snap     (snap_arr[c])
            );
        end
    endgenerate

    tsnap_target_cmp u_cmp (
        .now    (sys_time),
        .target (tgt_w),
        .hit    (tgt_hit)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[BIT_TGT]  = tgt_hit;
        set_vec[BIT_SLV]  = cap_vec[CH_SLV];
        set_vec[BIT_MST]  = cap_vec[CH_MST];
        set_vec[BIT_PPS]  = pps_tick;
    end

    tsnap_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .set_vec  (set_vec),
        .snap_slv (snap_arr[CH_SLV]),
        .snap_mst (snap_arr[CH_MST]),
        .rdata    (reg_rdata),
        .irq      (irq),
        .ctrl_q   (ctrl_w),
        .evt_q    (evt_w),
        .tgt_q    (tgt_w)
    );

endmodule

// File: rtl/tsnap_checker.sv
module tsnap_checker
    import tsnap_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pps_tick,
    input logic             irq,
    input stamp_t           sys_time,
    input stamp_t           target,
    input logic [EVT_W-1:0] evt,
    input logic [EVT_W-1:0] ctrl,
    input logic             ack_slv,
    input logic             slv_cap,
    input stamp_t           slv_snap,
    input stamp_t           mst_snap
);

    AST_TGT_SETS: assert property (@(posedge clk) disable iff (rst)
        (sys_time >= target && !ctrl[BIT_SRST]) |=> evt[BIT_TGT]); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (evt[BIT_SLV] && !ctrl[BIT_SRST] && !ack_slv) |=> evt[BIT_SLV]); // R6

    AST_PPS_SETS: assert property (@(posedge clk) disable iff (rst)
        (pps_tick && !ctrl[BIT_SRST]) |=> evt[BIT_PPS]); // R7

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ctrl[BIT_PPS:BIT_TGT] == '0) |-> !irq); // R8

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ctrl[BIT_SRST] |=> (evt == '0 && slv_snap == '0 && mst_snap == '0)); // R9

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!slv_cap && !ctrl[BIT_SRST]) |=> $stable(slv_snap)); // R4

    AST_NO_BIT0: assert property (@(posedge clk) disable iff (rst)
        !evt[BIT_SRST]); // R10

endmodule

bind tsnap_event_ctrl tsnap_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .pps_tick (pps_tick),
    .irq      (irq),
    .sys_time (sys_time),
    .target   (tgt_w),
    .evt      (evt_w),
    .ctrl     (ctrl_w),
    .ack_slv  (reg_wr && reg_addr == 3'd1 && reg_wdata[2]),
    .slv_cap  (cap_vec[0]),
    .slv_snap (snap_arr[0]),
    .mst_snap (snap_arr[1])
);

// File: tb/sim_tsnap_event_ctrl.sv
module sim_tsnap_event_ctrl;
    import tsnap_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] sys_time = '0;
    logic        aux_slave_in = 1'b0;
    logic        aux_master_in = 1'b0;
    logic        pps_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    tsnap_event_ctrl u0 (
        .clk(clk), .rst(rst), .sys_time(sys_time),
        .aux_slave_in(aux_slave_in), .aux_master_in(aux_master_in),
        .pps_tick(pps_tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // [17:14] mask ctrl[4:1], [13:11] trig {pps,mst,slv}, [10:6] ack, [5:1] event, [0] irq
    localparam logic [17:0] VEC [9] = '{
        {4'b0000, 3'b001, 5'b00000, 5'b00100, 1'b0},
        {4'b0010, 3'b000, 5'b00000, 5'b00100, 1'b1},
        {4'b0010, 3'b010, 5'b00100, 5'b01000, 1'b0},
        {4'b0100, 3'b000, 5'b00001, 5'b01000, 1'b1},
        {4'b1000, 3'b100, 5'b00000, 5'b11000, 1'b1},
        {4'b1000, 3'b000, 5'b10000, 5'b01000, 1'b0},
        {4'b1110, 3'b111, 5'b00000, 5'b11100, 1'b1},
        {4'b1110, 3'b000, 5'b11110, 5'b00000, 1'b0},
        {4'b0001, 3'b000, 5'b00000, 5'b00000, 1'b0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_stamp(input logic [2:0] lo_a, output logic [63:0] v);
        logic [31:0] h, l;
        rd_reg(lo_a + 3'd1, h);
        rd_reg(lo_a, l);
        v = {h, l};
    endtask

    task automatic trig(input logic [2:0] t);
        @(negedge clk);
        aux_slave_in = t[0]; aux_master_in = t[1]; pps_tick = t[2];
        @(negedge clk);
        pps_tick = 1'b0;
        tick(3);
        aux_slave_in = 1'b0; aux_master_in = 1'b0;
        tick(4);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] s;

        // R1: state during reset
        tick(3);
        rd_reg(SEL_CTRL, d);   chk("R1 ctrl in reset", d, 0);
        rd_reg(SEL_EVENT, d);  chk("R1 event in reset", d, 0);
        rd_stamp(SEL_SLV_LO, s); chk("R1 slave snap in reset", s, 0);
        rd_stamp(SEL_MST_LO, s); chk("R1 master snap in reset", s, 0);
        rd_stamp(SEL_TGT_LO, s); chk("R1 target in reset", s, 0);
        chk("R1 irq in reset", irq, 0);
        @(negedge clk) rst = 1'b0;

        // move target out of reach, clear its flag (R6)
        sys_time = 64'h10;
        wr_reg(SEL_TGT_HI, 32'hFFFF_FFFF);
        wr_reg(SEL_TGT_LO, 32'hFFFF_FFFF);
        wr_reg(SEL_EVENT, 32'h2);
        rd_reg(SEL_EVENT, d); chk("R6 target flag cleared", d, 0);

        // table: R2 R6 R7 R8
        for (int i = 0; i < 9; i++) begin
            logic [17:0] v;
            v = VEC[i];
            wr_reg(SEL_CTRL, {27'd0, v[17:14], 1'b0});
            if (v[13:11] != 3'b000) trig(v[13:11]);
            wr_reg(SEL_EVENT, {27'd0, v[10:6]});
            rd_reg(SEL_EVENT, d);
            chk($sformatf("R6 R7 table %0d event", i), d, {27'd0, v[5:1]});
            chk($sformatf("R8 table %0d irq", i), irq, v[0]);
        end

        // R2: latency and value of a slave capture
        wr_reg(SEL_CTRL, 32'h0);
        sys_time = 64'h0000_1234_ABCD_0000;
        reg_addr = SEL_EVENT;
        @(negedge clk) aux_slave_in = 1'b1;
        @(negedge clk); rd_reg(SEL_EVENT, d); chk("R2 no flag after 1 edge", d[2], 0);
        @(negedge clk); rd_reg(SEL_EVENT, d); chk("R2 no flag after 2 edges", d[2], 0);
        @(negedge clk); rd_reg(SEL_EVENT, d); chk("R2 flag on 3rd edge", d[2], 1);
        rd_stamp(SEL_SLV_LO, s); chk("R2 slave snapshot", s, 64'h0000_1234_ABCD_0000);

        // R3: held high, then falling
        sys_time = 64'h55;
        tick(6);
        rd_stamp(SEL_SLV_LO, s); chk("R3 held high no capture", s, 64'h0000_1234_ABCD_0000);
        aux_slave_in = 1'b0;
        tick(6);
        rd_stamp(SEL_SLV_LO, s); chk("R3 falling no capture", s, 64'h0000_1234_ABCD_0000);

        // R4: overwrite while pending
        sys_time = 64'h0000_00AA_0000_00BB;
        trig(3'b001);
        rd_reg(SEL_EVENT, d); chk("R4 flag still pending", d[2], 1);
        rd_stamp(SEL_SLV_LO, s); chk("R4 slave overwritten", s, 64'h0000_00AA_0000_00BB);
        sys_time = 64'hDEAD_0000_0000_BEEF;
        trig(3'b010);
        rd_stamp(SEL_MST_LO, s); chk("R2 master snapshot", s, 64'hDEAD_0000_0000_BEEF);
        rd_stamp(SEL_SLV_LO, s); chk("R4 slave untouched by master", s, 64'h0000_00AA_0000_00BB);

        // R5 / R6: target comparison
        wr_reg(SEL_EVENT, 32'h1E);
        sys_time = 64'd99;
        wr_reg(SEL_TGT_HI, 32'h0);
        wr_reg(SEL_TGT_LO, 32'd100);
        wr_reg(SEL_EVENT, 32'h2);
        tick(2);
        rd_reg(SEL_EVENT, d); chk("R5 below target", d, 0);
        sys_time = 64'd100;
        @(negedge clk); rd_reg(SEL_EVENT, d); chk("R5 equal sets flag", d[1], 1);
        sys_time = 64'd50;
        tick(2);
        rd_reg(SEL_EVENT, d); chk("R5 flag sticky", d[1], 1);
        wr_reg(SEL_EVENT, 32'h2);
        rd_reg(SEL_EVENT, d); chk("R6 clear below target", d[1], 0);
        sys_time = 64'd200;
        wr_reg(SEL_EVENT, 32'h2);
        rd_reg(SEL_EVENT, d); chk("R6 set beats clear", d[1], 1);
        sys_time = 64'h0000_0000_FFFF_FFFF;
        wr_reg(SEL_TGT_HI, 32'h1);
        wr_reg(SEL_TGT_LO, 32'h0);
        wr_reg(SEL_EVENT, 32'h2);
        rd_reg(SEL_EVENT, d); chk("R5 high word below", d[1], 0);
        sys_time = 64'h0000_0001_0000_0000;
        @(negedge clk); rd_reg(SEL_EVENT, d); chk("R5 high word reached", d[1], 1);

        // R9: soft clear
        wr_reg(SEL_CTRL, 32'h1E);
        chk("R8 target masked in", irq, 1);
        wr_reg(SEL_CTRL, 32'h1F);
        tick(1);
        rd_reg(SEL_EVENT, d); chk("R9 events held clear", d, 0);
        rd_stamp(SEL_SLV_LO, s); chk("R9 slave cleared", s, 0);
        rd_stamp(SEL_MST_LO, s); chk("R9 master cleared", s, 0);
        chk("R9 irq low", irq, 0);
        trig(3'b100);
        rd_reg(SEL_EVENT, d); chk("R9 tick ignored", d, 0);
        rd_reg(SEL_CTRL, d); chk("R9 masks kept", d, 32'h1F);
        rd_stamp(SEL_TGT_LO, s); chk("R9 target kept", s, 64'h0000_0001_0000_0000);
        wr_reg(SEL_CTRL, 32'h1E);
        trig(3'b100);
        rd_reg(SEL_EVENT, d); chk("R7 R10 tick after release", d, 32'h12);

        // R10: unimplemented bits
        wr_reg(SEL_CTRL, 32'hFFFF_FFE0);
        rd_reg(SEL_CTRL, d); chk("R10 ctrl upper bits", d, 0);
        wr_reg(SEL_EVENT, 32'hFFFF_FFE1);
        rd_reg(SEL_EVENT, d); chk("R10 event upper write", d, 32'h12);

        // R1: reset again
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        rd_reg(SEL_EVENT, d); chk("R1 event after reset", d, 0);
        rd_stamp(SEL_TGT_LO, s); chk("R1 target after reset", s, 0);
        chk("R1 irq after reset", irq, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule